// File: doc/BRIEF.md
# Two-Wire Bus Controller Register Block

This block is the register front end for a push-pull two-wire serial bus engine. Software uses a simple 32-bit read/write bus to set a clock divider and output delay, a target register address, a transfer direction and byte count, and outgoing data. It then launches a transfer. The block passes these settings to the bus engine and hands it one-cycle start, abort and soft-reset strobes. It turns the engine's done and error results into sticky status flags, which software clears by writing one, and it drives one level interrupt.

A start request made while a transfer is running does not disturb that transfer. It raises a separate load-busy flag instead. The start bit reads back as one for as long as the engine is busy. A line-control register lets software take direct control of the clock and data pins and read their live levels. A soft reset returns every register to its reset value and strobes the engine's own reset.

Top module: `tw_regif`

## Requirements
- R1: After reset every register reads 0, and `irq`, `eng_start`, `eng_abort`, `eng_srst` and all four pin-override outputs are 0.
- R2: The configuration registers read back only their defined fields, and every other bit reads 0:
  - clock config at 0x04: divider in bits 7:0, output delay in bits 10:8
  - interrupt enable at 0x08: bits 2:0
  - register address at 0x10 and 0x14: bits 7:0
  - length at 0x18: read select in bit 4, byte count minus one in bits 2:0
  - data at 0x1C and 0x20: all 32 bits
- R3: A write to control (0x00) with bit 7 set and bit 0 clear, made while idle, raises `eng_start` for exactly the one cycle after the write edge. Control bit 7 then reads 1 until the engine finishes.
- R4: `eng_done` while busy clears control bit 7 and sets status (0x0C) bit 0. If length bit 4 is set, data 0x1C and 0x20 take `eng_rdata0` and `eng_rdata1`; otherwise they keep their values.
- R5: `eng_err` while busy clears control bit 7, sets status bit 1 and puts `eng_err_id` into status bits 15:8.
- R6: A start write while busy sets status bit 2, produces no `eng_start`, and leaves control bit 7 at 1.
- R7: Writing 1 to a status bit among 2:0 clears it, and writing 0 leaves it. Clearing bit 1 also clears bits 15:8.
- R8: `irq` is 1 exactly when control bit 1 (global enable) is set and some status bit among 2:0 is set together with the same bit of interrupt enable.
- R9: A control write with bit 6 set while busy raises `eng_abort` for one cycle. The same write while idle does nothing. Control bit 6 always reads 0.
- R10: Line control (0x24) bits 3:0 drive `sda_oe`, `sda_out`, `scl_oe`, `scl_out` in that order. Bits 4 and 5 read the live `sda_in` and `scl_in`.
- R11: A control write with bit 0 set returns every register to its reset value at that edge. It raises `eng_srst` for one cycle, during which control bit 0 reads 1.
- R12: `eng_done` or `eng_err` while idle changes no status, error-identifier or data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle transfer launch to engine |
| eng_abort | output | 1 | One-cycle abort request to engine |
| eng_srst | output | 1 | One-cycle engine reset |
| eng_done | input | 1 | Engine reports transfer complete |
| eng_err | input | 1 | Engine reports transfer error |
| eng_err_id | input | 8 | Engine error identifier |
| eng_rdata0 | input | 32 | Received data, first word |
| eng_rdata1 | input | 32 | Received data, second word |
| cfg_div | output | 8 | Clock divider |
| cfg_dly | output | 3 | Data output delay |
| xfer_reg0 | output | 8 | Target register address 0 |
| xfer_reg1 | output | 8 | Target register address 1 |
| xfer_read | output | 1 | Transfer is a read |
| xfer_cnt | output | 3 | Byte count minus one |
| xfer_wdata0 | output | 32 | Outgoing data, first word |
| xfer_wdata1 | output | 32 | Outgoing data, second word |
| sda_in | input | 1 | Live data pin level |
| scl_in | input | 1 | Live clock pin level |
| sda_oe | output | 1 | Data pin override enable |
| sda_out | output | 1 | Data pin override level |
| scl_oe | output | 1 | Clock pin override enable |
| scl_out | output | 1 | Clock pin override level |

## Verification
The bench walks every combination of the three status flags against all eight enable masks with global enable off and on. A wrong mask or a missing global gate shows up as a spurious or missing interrupt. It issues a second start during a running transfer: a design that restarts there emits a second start strobe or loses the busy bit. Engine results that arrive while idle are checked for leaking into status or data. A soft reset is checked for leaving any register, the busy bit or the interrupt standing.

// File: rtl/tw_regif.sv
module tw_regif #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          eng_start,
  output logic          eng_abort,
  output logic          eng_srst,
  input  logic          eng_done,
  input  logic          eng_err,
  input  logic [BW-1:0] eng_err_id,
  input  logic [DW-1:0] eng_rdata0,
  input  logic [DW-1:0] eng_rdata1,
  output logic [BW-1:0] cfg_div,
  output logic [2:0]    cfg_dly,
  output logic [BW-1:0] xfer_reg0,
  output logic [BW-1:0] xfer_reg1,
  output logic          xfer_read,
  output logic [2:0]    xfer_cnt,
  output logic [DW-1:0] xfer_wdata0,
  output logic [DW-1:0] xfer_wdata1,
  input  logic          sda_in,
  input  logic          scl_in,
  output logic          sda_oe,
  output logic          sda_out,
  output logic          scl_oe,
  output logic          scl_out
);
  localparam logic [AW-1:0] A_CTRL = AW'(6'h00), A_CLK = AW'(6'h04), A_IEN = AW'(6'h08),
                            A_STS  = AW'(6'h0C), A_RG0 = AW'(6'h10), A_RG1 = AW'(6'h14),
                            A_LEN  = AW'(6'h18), A_DT0 = AW'(6'h1C), A_DT1 = AW'(6'h20),
                            A_LINE = AW'(6'h24);

  logic          busy, gie, start_q, abort_q, srst_q;
  logic [2:0]    ien, st;
  logic [BW-1:0] err_id;
  logic [3:0]    line;

  wire wr_ctrl   = bus_wr && bus_addr == A_CTRL;
  wire soft_req  = wr_ctrl && bus_wdata[0];
  wire start_req = wr_ctrl && bus_wdata[7] && !bus_wdata[0];
  wire abort_req = wr_ctrl && bus_wdata[6] && !bus_wdata[0];
  wire got_done  = busy && eng_done;
  wire got_err   = busy && eng_err;
  wire fin       = got_done || got_err;
  wire w1c       = bus_wr && bus_addr == A_STS;
  wire [2:0] clr = w1c ? bus_wdata[2:0] : 3'b000;
  wire [2:0] set = {start_req && busy, got_err, got_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_req) begin
      busy <= 1'b0; gie <= 1'b0; start_q <= 1'b0; abort_q <= 1'b0;
      srst_q <= rst_n; ien <= '0; st <= '0; err_id <= '0; line <= '0;
      cfg_div <= '0; cfg_dly <= '0; xfer_reg0 <= '0; xfer_reg1 <= '0;
      xfer_read <= 1'b0; xfer_cnt <= '0; xfer_wdata0 <= '0; xfer_wdata1 <= '0;
    end else begin
      srst_q  <= 1'b0;
      start_q <= start_req && !busy;
      abort_q <= abort_req && busy && !fin;
      if (wr_ctrl) gie <= bus_wdata[1];
      if (fin) busy <= 1'b0;
      else if (start_req) busy <= 1'b1;
      st <= (st & ~clr) | set;
      if (got_err) err_id <= eng_err_id;
      else if (w1c && bus_wdata[1]) err_id <= '0;
      if (bus_wr) begin
        case (bus_addr)
          A_CLK:  begin cfg_div <= bus_wdata[BW-1:0]; cfg_dly <= bus_wdata[10:8]; end
          A_IEN:  ien <= bus_wdata[2:0];
          A_RG0:  xfer_reg0 <= bus_wdata[BW-1:0];
          A_RG1:  xfer_reg1 <= bus_wdata[BW-1:0];
          A_LEN:  begin xfer_read <= bus_wdata[4]; xfer_cnt <= bus_wdata[2:0]; end
          A_DT0:  xfer_wdata0 <= bus_wdata;
          A_DT1:  xfer_wdata1 <= bus_wdata;
          A_LINE: line <= bus_wdata[3:0];
          default: ;
        endcase
      end
      if (got_done && xfer_read) begin
        xfer_wdata0 <= eng_rdata0;
        xfer_wdata1 <= eng_rdata1;
      end
    end
  end

  assign eng_start = start_q;
  assign eng_abort = abort_q;
  assign eng_srst  = srst_q;
  assign irq       = gie && |(ien & st);
  assign {scl_out, scl_oe, sda_out, sda_oe} = line;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = DW'({busy, 5'b0, gie, srst_q});
      A_CLK:  bus_rdata = DW'({cfg_dly, cfg_div});
      A_IEN:  bus_rdata = DW'(ien);
      A_STS:  bus_rdata = DW'({err_id, 5'b0, st});
      A_RG0:  bus_rdata = DW'(xfer_reg0);
      A_RG1:  bus_rdata = DW'(xfer_reg1);
      A_LEN:  bus_rdata = DW'({xfer_read, 1'b0, xfer_cnt});
      A_DT0:  bus_rdata = xfer_wdata0;
      A_DT1:  bus_rdata = xfer_wdata1;
      A_LINE: bus_rdata = DW'({scl_in, sda_in, line});
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tw_regif_chk.sv
module tw_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       soft_req,
  input logic       start_req,
  input logic       eng_start,
  input logic       eng_abort,
  input logic       eng_srst,
  input logic       eng_done,
  input logic       eng_err,
  input logic [7:0] eng_err_id,
  input logic [2:0] st,
  input logic [7:0] err_id
);
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_req && !busy |=> busy && eng_start);
  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_done && !soft_req |=> !busy && st[0]);
  p_err_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_err && !soft_req |=> st[1] && err_id == $past(eng_err_id));
  p_loadbusy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_req && busy && !eng_done && !eng_err |=> st[2] && busy && !eng_start);
  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> !eng_abort);
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_req |=> eng_srst && !busy && st == 3'b000 && err_id == 8'h00);
endmodule

bind tw_regif tw_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .soft_req(soft_req), .start_req(start_req),
  .eng_start(eng_start), .eng_abort(eng_abort), .eng_srst(eng_srst),
  .eng_done(eng_done), .eng_err(eng_err), .eng_err_id(eng_err_id),
  .st(st), .err_id(err_id)
);

// File: tb/tw_regif_bench.sv
module tw_regif_bench;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, eng_start, eng_abort, eng_srst;
  logic eng_done = 0, eng_err = 0;
  logic [7:0] eng_err_id = 0;
  logic [31:0] eng_rdata0 = 0, eng_rdata1 = 0;
  logic [7:0] cfg_div, xfer_reg0, xfer_reg1;
  logic [2:0] cfg_dly, xfer_cnt;
  logic xfer_read;
  logic [31:0] xfer_wdata0, xfer_wdata1;
  logic sda_in = 0, scl_in = 0;
  logic sda_oe, sda_out, scl_oe, scl_out;
  int tests = 0, fails = 0;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  tw_regif u_tw_regif (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic done_pulse(input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk); eng_done = 1; eng_rdata0 = d0; eng_rdata1 = d1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic err_pulse(input logic [7:0] id);
    @(negedge clk); eng_err = 1; eng_err_id = id;
    @(negedge clk); eng_err = 0;
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a <= 'h24; a += 4) begin rd(a[5:0], r); chk("R1 reset reg", r & 32'hFFFF_FFCF, 0); end
    chk("R1 outputs", {irq, eng_start, eng_abort, eng_srst, sda_oe, sda_out, scl_oe, scl_out}, 0);

    // R2 walking-one sweep on each config register
    for (int b = 0; b < 32; b++) begin
      logic [31:0] v = 32'h1 << b;
      wr('h04, v); rd('h04, r); chk("R2 clock config", r, v & 32'h7FF);
      wr('h08, v); rd('h08, r); chk("R2 irq enable", r, v & 32'h7);
      wr('h10, v); rd('h10, r); chk("R2 reg addr 0", r, v & 32'hFF);
      wr('h14, v); rd('h14, r); chk("R2 reg addr 1", r, v & 32'hFF);
      wr('h18, v); rd('h18, r); chk("R2 length", r, v & 32'h17);
      wr('h1C, v); rd('h1C, r); chk("R2 data 0", r, v);
      wr('h20, ~v); rd('h20, r); chk("R2 data 1", r, ~v);
    end
    wr('h04, 32'h0000_05A3); chk("R2 cfg pins", {21'b0, cfg_dly, cfg_div}, 32'h5A3);
    wr('h08, 0);

    // R3 start, R4 done with read length
    wr('h18, 32'h13); wr('h1C, 32'h1111_1111); wr('h20, 32'h2222_2222);
    wr('h00, 32'h80);
    chk("R3 start strobe", eng_start, 1);
    rd('h00, r); chk("R3 busy readback", r, 32'h80);
    @(negedge clk); chk("R3 start one cycle", eng_start, 0);
    rd('h00, r); chk("R3 still busy", r, 32'h80);
    done_pulse(32'hDEAD_BEEF, 32'hCAFE_F00D);
    rd('h00, r); chk("R4 busy cleared", r, 0);
    rd('h0C, r); chk("R4 done flag", r, 32'h1);
    rd('h1C, r); chk("R4 read data 0", r, 32'hDEAD_BEEF);
    rd('h20, r); chk("R4 read data 1", r, 32'hCAFE_F00D);
    wr('h0C, 7);
    // R4 write transfer keeps data
    wr('h18, 32'h01); wr('h00, 32'h80); done_pulse(32'h5, 32'h6);
    rd('h1C, r); chk("R4 write keeps data", r, 32'hDEAD_BEEF);
    wr('h0C, 7);

    // R5 error with identifier
    wr('h00, 32'h80); err_pulse(8'hA5);
    rd('h0C, r); chk("R5 error flag and id", r, 32'hA502);
    rd('h00, r); chk("R5 busy cleared", r, 0);
    // R7 W1C
    wr('h0C, 32'h1); rd('h0C, r); chk("R7 write one other bit", r, 32'hA502);
    wr('h0C, 32'h2); rd('h0C, r); chk("R7 clear error clears id", r, 0);

    // R6 load-busy, R9 abort
    wr('h00, 32'h80); @(negedge clk);
    wr('h00, 32'h80);
    chk("R6 no second start", eng_start, 0);
    rd('h0C, r); chk("R6 load-busy flag", r, 32'h4);
    rd('h00, r); chk("R6 still busy", r, 32'h80);
    wr('h00, 32'h40);
    chk("R9 abort strobe", eng_abort, 1);
    rd('h00, r); chk("R9 abort reads zero", r, 32'h80);
    @(negedge clk); chk("R9 abort one cycle", eng_abort, 0);
    done_pulse(0, 0);
    wr('h00, 32'h40); chk("R9 abort ignored idle", eng_abort, 0);
    wr('h0C, 7);

    // R12 idle engine events ignored
    wr('h18, 32'h10); wr('h1C, 32'h0BAD_0001);
    done_pulse(32'hFFFF_FFFF, 32'hFFFF_FFFF); err_pulse(8'h77);
    rd('h0C, r); chk("R12 status unchanged", r, 0);
    rd('h1C, r); chk("R12 data unchanged", r, 32'h0BAD_0001);

    // R8 interrupt sweep
    for (int s = 0; s < 8; s++) begin
      wr('h0C, 7);
      wr('h00, 32'h80); wr('h00, 32'h80); done_pulse(0, 0);
      wr('h00, 32'h80); err_pulse(8'h3C);
      wr('h0C, ~s & 7);
      rd('h0C, r); chk("R7 selective clear", r[2:0], s[2:0]);
      for (int e = 0; e < 8; e++) begin
        wr('h08, e);
        for (int g = 0; g < 2; g++) begin
          wr('h00, g << 1);
          @(negedge clk);
          chk("R8 irq", irq, (g == 1) && ((e & s) != 0));
        end
      end
    end

    // R10 line override and readback
    for (int v = 0; v < 16; v++) begin
      wr('h24, v);
      chk("R10 override outputs", {scl_out, scl_oe, sda_out, sda_oe}, v[3:0]);
      rd('h24, r); chk("R10 override readback", r[3:0], v[3:0]);
    end
    for (int p = 0; p < 4; p++) begin
      sda_in = p[0]; scl_in = p[1];
      rd('h24, r); chk("R10 live pins", r[5:4], p[1:0]);
    end

    // R11 soft reset
    wr('h04, 32'h3FF); wr('h08, 7); wr('h00, 32'h82); wr('h00, 32'h82);
    chk("R11 precondition irq", irq, 1);
    wr('h00, 32'h1);
    chk("R11 engine reset strobe", eng_srst, 1);
    rd('h00, r); chk("R11 ctrl bit0 high", r, 32'h1);
    rd('h04, r); chk("R11 clock config cleared", r, 0);
    rd('h0C, r); chk("R11 status cleared", r, 0);
    rd('h24, r); chk("R11 line cleared", r[3:0], 0);
    chk("R11 irq cleared", irq, 0);
    @(negedge clk);
    chk("R11 strobe one cycle", eng_srst, 0);
    rd('h00, r); chk("R11 ctrl clear", r, 0);

    finish_up();
  end
endmodule